// File: doc/BRIEF.md
# Burst Read Latency and Ready Generator

This block is the device-side sequencer for synchronous burst reads on a clocked memory port. The host enables the device by pulling the active-low chip enable low. It then strobes the active-low address-valid input together with a start address. The block waits a programmable number of clock cycles and then presents one data word on every clock. Each clock steps an internal address counter, either linearly or inside an aligned wrap block. The memory array is a combinational lookup of the current address.

A ready output tells the host when words are valid. Its active level can be programmed, and it can lead the first word by one cycle. All of these settings come from a 16-bit configuration word loaded through a write strobe. Its fields select the initial latency, the ready polarity, the ready lead and the burst wrap length. Releasing chip enable aborts a burst at once. A fresh address strobe during a burst restarts the sequence.

Top module: `burst_latency_ctrl`

## Requirements
- R1: After reset the outputs are idle (`dataValid`=0, `dataOut`=0, `rdy`=0). The configuration word resets to 0x5500, which gives a latency of 13 cycles, active-high ready with a one-cycle lead, and a continuous burst.
- R2: The start address is taken from `addrIn` on the rising edge where `ceN`=0 and `advN`=0. Later changes on `addrIn` have no effect on the burst.
- R3: The latency field is configuration bits [14:11] (bit 14 most significant). A field value n from 0 to 10 gives n+3 cycles; values 11 to 15 give 13. If the address is captured at edge E, the first word is valid in the cycle that follows edge E+latency.
- R4: While `dataValid`=1, `dataOut` equals the current address XOR 0x5A3C. While `dataValid`=0, `dataOut` is 0.
- R5: Once data is flowing, each rising edge with `ceN`=0 and `advN`=1 advances the address by one, giving one new word per clock. A continuous burst rolls over from 0xFFFF to 0x0000.
- R6: The burst code is configuration bits [2:0]. Code 010 wraps inside an aligned 8-word block, 011 inside 16 words and 100 inside 32 words. All other codes are continuous. The code is latched at address capture.
- R7: Configuration bit 10 sets the ready polarity: 1 means `rdy` is active high, 0 means active low. The inactive level is the opposite level.
- R8: Configuration bit 8 sets the ready timing. With 0, ready is active exactly in the cycles where `dataValid`=1. With 1, ready turns active one cycle before the first word and stays active through the data.
- R9: While `ceN`=1, `dataValid` and `dataOut` are 0 in the same cycle and `rdy` is at its inactive level. The sequencer stays idle until a new address capture.
- R10: An address capture during a burst restarts the sequence. The next cycle carries no data, and data resumes from the new address after a full new latency.
- R11: An `advN` pulse while `ceN`=1 is ignored. Enabling the chip afterwards without a new strobe produces no data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Memory clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Loads `cfgWrData` into the configuration word |
| cfgWrData | input | 16 | Configuration word: [14:11] latency, [10] ready polarity, [8] ready lead, [2:0] burst code |
| ceN | input | 1 | Active-low chip enable; high aborts the burst |
| advN | input | 1 | Active-low address-valid strobe |
| addrIn | input | 16 | Burst start address |
| dataOut | output | 16 | Read word, zero when not valid |
| dataValid | output | 1 | High in every cycle that carries a word |
| rdy | output | 1 | Ready indication with programmable polarity and lead |

## Verification
A wait counter that was loaded or decoded wrongly moves the first `dataValid` cycle off its expected edge. This shows up as soon as that burst reaches the end of its latency, and the same cycle also shifts the `rdy` edge. A wrong address step or wrap mask gives a wrong word the first time the burst crosses a block boundary. In a wrapped burst that is within 8, 16 or 32 words; in a continuous burst it is the first step. A state machine that ignores `ceN` or a stray strobe leaves a valid word or an active ready on the very next cycle, when the ports should show an idle bus.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  // configuration field positions (decoded by the sequencer)
  localparam int WAIT_MSB   = 14;
  localparam int WAIT_LSB   = 11;
  localparam int WFLD_W     = WAIT_MSB - WAIT_LSB + 1;
  localparam int POL_BIT    = 10;
  localparam int LEAD_BIT   = 8;
  localparam int BL_MSB     = 2;
  localparam int BL_LSB     = 0;

  localparam int WAIT_MIN   = 3;
  localparam int WAIT_MAX   = 13;

  localparam logic [15:0] CFG_RESET = 16'h5500;

  // smallest wrap block is 2**WRAP_LOG_BASE words
  localparam int WRAP_LOG_BASE = 3;
  localparam int NUM_WRAP      = 3;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_WAIT,
    SEQ_DATA
  } seqState_e;

  typedef enum logic [1:0] {
    WRAP_NONE,
    WRAP_8,
    WRAP_16,
    WRAP_32
  } wrapSel_e;

  // strobes from the controller to the datapath
  typedef struct packed {
    logic loadAddr;
    logic stepAddr;
    logic showData;
    logic readyLead;
  } seqStrobe_t;

endpackage

// File: rtl/burst_cfg_reg.sv
module burst_cfg_reg
  import burst_seq_pkg::*;
#(
  parameter int CFG_W = 16,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [CFG_W-1:0] wrData,
  output logic [CNT_W-1:0] waitCycles,
  output logic             rdyPol,
  output logic             rdyLead,
  output wrapSel_e         wrapSel
);

  logic [WFLD_W-1:0]      waitField;
  logic                   polBit;
  logic                   leadBit;
  logic [BL_MSB-BL_LSB:0] blCode;
  logic                   cfgUnused;

  // only the decoded fields are kept as flops
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitField <= CFG_RESET[WAIT_MSB:WAIT_LSB];
      polBit    <= CFG_RESET[POL_BIT];
      leadBit   <= CFG_RESET[LEAD_BIT];
      blCode    <= CFG_RESET[BL_MSB:BL_LSB];
    end else if (wrEn) begin
      waitField <= wrData[WAIT_MSB:WAIT_LSB];
      polBit    <= wrData[POL_BIT];
      leadBit   <= wrData[LEAD_BIT];
      blCode    <= wrData[BL_MSB:BL_LSB];
    end
  end

  assign cfgUnused = ^{wrData[CFG_W-1:WAIT_MSB+1], wrData[POL_BIT-1:LEAD_BIT+1],
                       wrData[LEAD_BIT-1:BL_MSB+1]};

  // latency decode with clamp at the top of the range
  always_comb begin
    if (waitField > WFLD_W'(WAIT_MAX - WAIT_MIN))
      waitCycles = CNT_W'(WAIT_MAX);
    else
      waitCycles = CNT_W'(waitField) + CNT_W'(WAIT_MIN);
  end

  always_comb begin
    case (blCode)
      3'b010:  wrapSel = WRAP_8;
      3'b011:  wrapSel = WRAP_16;
      3'b100:  wrapSel = WRAP_32;
      default: wrapSel = WRAP_NONE;
    endcase
  end

  assign rdyPol  = polBit;
  assign rdyLead = leadBit;

endmodule

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ceN,
  input  logic             advN,
  input  logic [CNT_W-1:0] waitCycles,
  output seqStrobe_t       strobe
);

  seqState_e        state, stateNext;
  logic [CNT_W-1:0] waitCnt, waitCntNext;
  logic             capture;
  logic             lastWait;

  assign capture  = !ceN && !advN;
  assign lastWait = (state == SEQ_WAIT) && (waitCnt == '0);

  always_comb begin
    stateNext   = state;
    waitCntNext = waitCnt;
    if (ceN) begin
      stateNext   = SEQ_IDLE;
      waitCntNext = '0;
    end else if (!advN) begin
      stateNext   = SEQ_WAIT;
      waitCntNext = waitCycles - CNT_W'(1);
    end else begin
      case (state)
        SEQ_WAIT: begin
          if (waitCnt == '0) stateNext   = SEQ_DATA;
          else               waitCntNext = waitCnt - CNT_W'(1);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= SEQ_IDLE;
      waitCnt <= '0;
    end else begin
      state   <= stateNext;
      waitCnt <= waitCntNext;
    end
  end

  always_comb begin
    strobe.loadAddr  = capture;
    strobe.stepAddr  = !ceN && advN && (state == SEQ_DATA);
    strobe.showData  = !ceN && (state == SEQ_DATA);
    // next cycle carries a word
    strobe.readyLead = !ceN && advN && (lastWait || (state == SEQ_DATA));
  end

endmodule

// File: rtl/burst_seq_dpath.sv
module burst_seq_dpath
  import burst_seq_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter int                DATA_W   = 16,
  parameter logic [DATA_W-1:0] MEM_SEED = 16'h5A3C
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [ADDR_W-1:0] addrIn,
  input  wrapSel_e          wrapSel,
  input  logic              rdyPol,
  input  logic              rdyLead,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataValid,
  output logic              rdy
);

  logic [ADDR_W-1:0] curAddr;
  logic [ADDR_W-1:0] linNext;
  logic [ADDR_W-1:0] nextAddr;
  logic [ADDR_W-1:0] wrapNext [NUM_WRAP];
  wrapSel_e          wrapLatched;
  logic              rdyActive;

  assign linNext = curAddr + ADDR_W'(1);

  for (genvar g = 0; g < NUM_WRAP; g++) begin : gWrap
    localparam logic [ADDR_W-1:0] BLK_MASK = ADDR_W'((1 << (WRAP_LOG_BASE + g)) - 1);
    assign wrapNext[g] = (curAddr & ~BLK_MASK) | (linNext & BLK_MASK);
  end

  always_comb begin
    case (wrapLatched)
      WRAP_8:  nextAddr = wrapNext[0];
      WRAP_16: nextAddr = wrapNext[1];
      WRAP_32: nextAddr = wrapNext[2];
      default: nextAddr = linNext;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr     <= '0;
      wrapLatched <= WRAP_NONE;
    end else if (strobe.loadAddr) begin
      curAddr     <= addrIn;
      wrapLatched <= wrapSel;
    end else if (strobe.stepAddr) begin
      curAddr     <= nextAddr;
    end
  end

  // array model: address spread over the word, scrambled by a seed
  function automatic logic [DATA_W-1:0] memWord(input logic [ADDR_W-1:0] a);
    logic [DATA_W-1:0] w;
    for (int i = 0; i < DATA_W; i++) w[i] = a[i % ADDR_W];
    return w ^ MEM_SEED;
  endfunction

  assign dataValid = strobe.showData;
  assign dataOut   = strobe.showData ? memWord(curAddr) : '0;
  assign rdyActive = rdyLead ? strobe.readyLead : strobe.showData;
  assign rdy       = rdyPol ? rdyActive : !rdyActive;

endmodule

// File: rtl/burst_latency_ctrl.sv
module burst_latency_ctrl
  import burst_seq_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter int                DATA_W   = 16,
  parameter int                CFG_W    = 16,
  parameter int                CNT_W    = 4,
  parameter logic [DATA_W-1:0] MEM_SEED = 16'h5A3C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [CFG_W-1:0]  cfgWrData,
  input  logic              ceN,
  input  logic              advN,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataValid,
  output logic              rdy
);

  logic [CNT_W-1:0] cfgWaitCycles;
  logic             cfgRdyPol;
  logic             cfgRdyLead;
  wrapSel_e         cfgWrapSel;
  seqStrobe_t       seqStrobe;

  burst_cfg_reg #(.CFG_W(CFG_W), .CNT_W(CNT_W)) cfg_i (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (cfgWrEn),
    .wrData    (cfgWrData),
    .waitCycles(cfgWaitCycles),
    .rdyPol    (cfgRdyPol),
    .rdyLead   (cfgRdyLead),
    .wrapSel   (cfgWrapSel)
  );

  burst_seq_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .ceN       (ceN),
    .advN      (advN),
    .waitCycles(cfgWaitCycles),
    .strobe    (seqStrobe)
  );

  burst_seq_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MEM_SEED(MEM_SEED)) dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (seqStrobe),
    .addrIn   (addrIn),
    .wrapSel  (cfgWrapSel),
    .rdyPol   (cfgRdyPol),
    .rdyLead  (cfgRdyLead),
    .dataOut  (dataOut),
    .dataValid(dataValid),
    .rdy      (rdy)
  );

endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              ceN,
  input logic              advN,
  input logic [DATA_W-1:0] dataOut,
  input logic              dataValid,
  input logic              rdy,
  input logic              rdyPol,
  input logic              rdyLead
);

  // edges since the last address capture, saturating
  logic [3:0] sinceCap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 sinceCap <= 4'hF;
    else if (!ceN && !advN)    sinceCap <= 4'h0;
    else if (sinceCap != 4'hF) sinceCap <= sinceCap + 4'h1;
  end

  // R9
  ce_blocks_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    ceN |-> !dataValid);

  // R9
  ce_idles_rdy_chk: assert property (@(posedge clk) disable iff (!rstN)
    ceN |-> (rdy == !rdyPol));

  // R4
  zero_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !dataValid |-> (dataOut == '0));

  // R3
  latency_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataValid) |-> (sinceCap >= 4'd3 && sinceCap <= 4'd13));

  // R10
  restart_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ceN && !advN) |=> !dataValid);

  // R8
  rdy_same_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ceN && !rdyLead) |-> (rdy == (rdyPol ? dataValid : !dataValid)));

endmodule

bind burst_latency_ctrl burst_seq_chk #(.DATA_W(DATA_W)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .ceN      (ceN),
  .advN     (advN),
  .dataOut  (dataOut),
  .dataValid(dataValid),
  .rdy      (rdy),
  .rdyPol   (cfgRdyPol),
  .rdyLead  (cfgRdyLead)
);

// File: tb/burst_latency_ctrl_tb_top.sv
module burst_latency_ctrl_tb_top;

  localparam logic [15:0] SEED = 16'h5A3C;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [15:0] cfgWrData = '0;
  logic        ceN = 1'b1;
  logic        advN = 1'b1;
  logic [15:0] addrIn = '0;
  logic [15:0] dataOut;
  logic        dataValid;
  logic        rdy;

  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;
  string       curReq = "R1";
  logic [15:0] expQ [$];
  logic [15:0] monExp;

  always #10 clk = ~clk;

  burst_latency_ctrl dut_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .ceN(ceN), .advN(advN), .addrIn(addrIn),
    .dataOut(dataOut), .dataValid(dataValid), .rdy(rdy)
  );

  function automatic logic [15:0] memOf(input logic [15:0] a);
    return a ^ SEED;
  endfunction

  function automatic logic [15:0] nextA(input logic [15:0] a, input int len);
    logic [15:0] m;
    if (len == 0) return a + 16'd1;
    m = 16'(len - 1);
    return (a & ~m) | ((a + 16'd1) & m);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: pops one expected word per valid cycle
  always @(negedge clk) begin
    #3;
    if (rstN && dataValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, curReq, "unexpected word", int'(dataOut), 0);
      end else begin
        monExp = expQ.pop_front();
        check(dataOut == monExp, curReq, "data word", int'(dataOut), int'(monExp));
      end
    end
  end

  task automatic cfgWrite(input logic [3:0] fld, input bit pol, input bit lead,
                          input logic [2:0] code);
    @(negedge clk);
    cfgWrEn   = 1'b1;
    cfgWrData = {1'b0, fld, pol, 1'b0, lead, 5'b0, code};
    @(negedge clk);
    cfgWrEn   = 1'b0;
    cfgWrData = '0;
  endtask

  task automatic capture(input logic [15:0] a);
    @(negedge clk);
    ceN = 1'b0; advN = 1'b0; addrIn = a;
    @(negedge clk);
    advN = 1'b1; addrIn = 16'hDEAD;   // R2: later address changes ignored
    #2;
  endtask

  // driver: queues the expected words, then checks valid and ready per cycle
  task automatic runWords(input logic [15:0] a0, input int w, input bit pol, input bit lead,
                          input int len, input int nWords, input int extra, input string req);
    logic [15:0] a;
    bit expV, expAct;
    a = a0;
    curReq = req;
    for (int k = 0; k < nWords + extra; k++) begin
      expQ.push_back(memOf(a));
      a = nextA(a, len);
    end
    for (int j = 0; j < w + nWords; j++) begin
      if (j > 0) begin @(negedge clk); #2; end
      expV   = (j >= w);
      expAct = lead ? (j >= w - 1) : (j >= w);
      check(dataValid == expV, req, $sformatf("valid at cycle %0d", j), int'(dataValid), int'(expV));
      check(rdy == (pol ? expAct : !expAct), req, $sformatf("rdy at cycle %0d", j),
            int'(rdy), int'(pol ? expAct : !expAct));
    end
  endtask

  task automatic abortBurst(input bit pol);
    @(negedge clk);
    ceN = 1'b1;
    #2;
    check(dataValid == 1'b0, "R9", "valid on abort", int'(dataValid), 0);
    check(dataOut == 16'h0, "R9", "data on abort", int'(dataOut), 0);
    check(rdy == !pol, "R9", "rdy on abort", int'(rdy), int'(!pol));
    for (int i = 0; i < 2; i++) begin
      @(negedge clk); #2;
      check(dataValid == 1'b0, "R9", "valid while disabled", int'(dataValid), 0);
    end
    check(expQ.size() == 0, curReq, "words left unread", expQ.size(), 0);
    expQ.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #2;
    // R1: idle after reset
    check(dataValid == 1'b0, "R1", "valid after reset", int'(dataValid), 0);
    check(dataOut == 16'h0, "R1", "data after reset", int'(dataOut), 0);
    check(rdy == 1'b0, "R1", "rdy after reset", int'(rdy), 0);

    // R1: default latency 13, lead, active high, continuous
    capture(16'h1234);
    runWords(16'h1234, 13, 1'b1, 1'b1, 0, 4, 0, "R1,R2,R4");
    abortBurst(1'b1);

    // R3 minimum latency, R5 rollover, R8 same-cycle ready
    cfgWrite(4'd0, 1'b1, 1'b0, 3'b000);
    capture(16'hFFFE);
    runWords(16'hFFFE, 3, 1'b1, 1'b0, 0, 5, 0, "R3,R5,R8");
    abortBurst(1'b1);

    // R3 clamp, R6 code 001 continuous, R7 active low
    cfgWrite(4'd15, 1'b0, 1'b1, 3'b001);
    #2;
    check(rdy == 1'b1, "R7", "inactive level when low-active", int'(rdy), 1);
    capture(16'h0040);
    runWords(16'h0040, 13, 1'b0, 1'b1, 0, 3, 0, "R3,R6,R7");
    abortBurst(1'b0);

    // R6 8-word wrap
    cfgWrite(4'd5, 1'b1, 1'b1, 3'b010);
    capture(16'h0105);
    runWords(16'h0105, 8, 1'b1, 1'b1, 8, 10, 0, "R6,R3");
    abortBurst(1'b1);

    // R6 16-word wrap, low-active same-cycle ready
    cfgWrite(4'd1, 1'b0, 1'b0, 3'b011);
    capture(16'h203E);
    runWords(16'h203E, 4, 1'b0, 1'b0, 16, 20, 0, "R6,R7,R8");
    abortBurst(1'b0);

    // R6 32-word wrap
    cfgWrite(4'd2, 1'b1, 1'b0, 3'b100);
    capture(16'h001F);
    runWords(16'h001F, 5, 1'b1, 1'b0, 32, 40, 0, "R6");
    abortBurst(1'b1);

    // R3 field 10 -> 13, R6 code 111 continuous
    cfgWrite(4'd10, 1'b1, 1'b1, 3'b111);
    capture(16'h00FE);
    runWords(16'h00FE, 13, 1'b1, 1'b1, 0, 4, 0, "R3,R6");
    abortBurst(1'b1);

    // R10 restart during a burst
    cfgWrite(4'd0, 1'b1, 1'b1, 3'b010);
    capture(16'h0300);
    runWords(16'h0300, 3, 1'b1, 1'b1, 8, 2, 1, "R10");
    capture(16'h0406);
    runWords(16'h0406, 3, 1'b1, 1'b1, 8, 5, 0, "R10");
    abortBurst(1'b1);

    // R11 strobe while disabled is ignored
    cfgWrite(4'd11, 1'b1, 1'b1, 3'b000);
    @(negedge clk);
    ceN = 1'b1; advN = 1'b0; addrIn = 16'h0777;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #2;
      check(dataValid == 1'b0 && rdy == 1'b0, "R11", "output while disabled",
            int'({dataValid, rdy}), 0);
    end
    @(negedge clk);
    advN = 1'b1; ceN = 1'b0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); #2;
      check(dataValid == 1'b0 && rdy == 1'b0, "R11", "output with no capture",
            int'({dataValid, rdy}), 0);
    end
    // R3: field 11 clamps to 13
    capture(16'h0500);
    runWords(16'h0500, 13, 1'b1, 1'b1, 0, 2, 0, "R3");
    abortBurst(1'b1);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1-R11 run: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule